// File: doc/BRIEF.md
# Overcurrent Sampling Shutdown Timer

This block watches the overcurrent flag of one switching-converter channel and decides between two reactions. The converter presents an already-synchronized comparator flag, and once per switching period a sample strobe marks the instant at which the flag is meaningful. The flag is ignored at every other time. A positive sample ends the gate drive for the present period through a one-cycle terminate pulse and starts a confirmation timer. That timer counts switching periods (strobes), not clock cycles.

A second positive sample seen inside a later window, from period `WIN_OPEN` to period `WIN_CLOSE` after the first event, latches a shutdown. A positive sample before the window opens only limits that one period. If the window closes with no overcurrent, the channel goes back to plain sampling, and the next positive sample counts as a new first event. The shutdown holds the terminate output high, which keeps the drive off, until reset or a clear input. All pins are plain control and status signals with no handshake, because one sample per strobe is the whole interface.

Top module: `ocp_shutdown_timer`

## Requirements
- R1: `oc_flag` has no effect in a cycle where `sample_stb` is low. Outside shutdown, `cycle_kill` stays low in the cycle after such a cycle.
- R2: When the block is idle (not in limit mode and not shut down), a strobe with `oc_flag` high drives `cycle_kill` high for exactly the one cycle after the strobe. `limit_active` goes high in that same cycle.
- R3: In limit mode the strobes after the first event are numbered 1, 2, 3 and so on, regardless of how many clocks separate them. A positive sample numbered below `WIN_OPEN` gives a one-cycle `cycle_kill` pulse. It does not shut down and does not restart the numbering.
- R4: A positive sample numbered from `WIN_OPEN` to `WIN_CLOSE` inclusive sets `shutdown` in the next cycle and clears `limit_active`. `shutdown` and `limit_active` are never high together.
- R5: If strobe number `WIN_CLOSE` has `oc_flag` low, `limit_active` falls in the next cycle. A later positive sample is then handled as a new first event (R2).
- R6: `shutdown` stays high, and `cycle_kill` stays high with it, until `clear` or reset. Strobes during shutdown have no effect.
- R7: `clear` high returns the block to idle in the next cycle, with all three outputs low. It takes priority over a strobe in the same cycle.
- R8: After reset `cycle_kill`, `shutdown` and `limit_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe at the sampling point of each switching period |
| oc_flag | input | 1 | Synchronized overcurrent comparator flag |
| clear | input | 1 | Restart: leave shutdown or limit mode and go idle |
| cycle_kill | output | 1 | Terminate gate drive for the present period; held high in shutdown |
| shutdown | output | 1 | Latched overcurrent shutdown |
| limit_active | output | 1 | Confirmation timer running (current-limit mode) |

## Verification
The bench sweeps the position of the second positive sample across every strobe number, from before the window to past it. It repeats this at several clock gaps between strobes, in a reduced configuration with a window from 3 to 6. The sweep catches an off-by-one at either window edge, where a design would shut down one period early or fail to shut down on the last period. It also catches a design that counts clocks instead of strobes, which would shift the window when strobes are spaced apart. A design that restarts the timer on an early hit is exposed because the window would then close late. Between strobes the flag is held high, so a design that looks at the flag without a strobe would pulse the terminate output. Clear is raised together with a positive strobe, so a design that lets the strobe win would come out of clear in limit mode.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    OCP_IDLE  = 2'd0,
    OCP_ARMED = 2'd1,
    OCP_TRIP  = 2'd2
  } ocp_state_e;
endpackage

// File: rtl/ocp_window_ctr.sv
module ocp_window_ctr #(
  parameter int unsigned WIN_OPEN  = 8,
  parameter int unsigned WIN_CLOSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic in_win,
  output logic win_last
);
  localparam int CNT_W = $clog2(WIN_CLOSE + 1);
  localparam int PW    = CNT_W + 1;
  localparam logic [PW-1:0] OPEN_V  = PW'(WIN_OPEN);
  localparam logic [PW-1:0] CLOSE_V = PW'(WIN_CLOSE);

  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pos;   // number of the strobe being taken now

  assign pos      = {1'b0, cnt} + PW'(1);
  assign in_win   = (pos >= OPEN_V) && (pos <= CLOSE_V);
  assign win_last = (pos == CLOSE_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= pos[CNT_W-1:0];
  end
endmodule

// File: rtl/ocp_ctrl.sv
module ocp_ctrl
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_stb,
  input  logic       oc_flag,
  input  logic       clear,
  input  logic       in_win,
  input  logic       win_last,
  output logic       ctr_clr,
  output logic       ctr_step,
  output ocp_state_e state,
  output logic       kill_q
);
  ocp_state_e state_d;
  logic       kill_d;

  always_comb begin
    state_d  = state;
    kill_d   = 1'b0;
    ctr_clr  = 1'b0;
    ctr_step = 1'b0;
    if (clear) begin
      state_d = OCP_IDLE;
      ctr_clr = 1'b1;
    end else begin
      unique case (state)
        OCP_IDLE: begin
          ctr_clr = 1'b1;
          if (sample_stb && oc_flag) begin
            state_d = OCP_ARMED;
            kill_d  = 1'b1;
          end
        end
        OCP_ARMED: begin
          if (sample_stb) begin
            ctr_step = 1'b1;
            kill_d   = oc_flag;
            if (oc_flag && in_win)  state_d = OCP_TRIP;
            else if (win_last)      state_d = OCP_IDLE;
          end
        end
        OCP_TRIP: kill_d = 1'b1;
        default:  state_d = OCP_IDLE;
      endcase
    end
    if (state_d == OCP_TRIP) kill_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= OCP_IDLE;
      kill_q <= 1'b0;
    end else begin
      state  <= state_d;
      kill_q <= kill_d;
    end
  end
endmodule

// File: rtl/ocp_shutdown_timer.sv
module ocp_shutdown_timer
  import ocp_pkg::*;
#(
  parameter int unsigned WIN_OPEN  = 8,
  parameter int unsigned WIN_CLOSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_stb,
  input  logic oc_flag,
  input  logic clear,
  output logic cycle_kill,
  output logic shutdown,
  output logic limit_active
);
  logic       ctr_clr, ctr_step, in_win, win_last, kill_q;
  ocp_state_e state;

  ocp_window_ctr #(.WIN_OPEN(WIN_OPEN), .WIN_CLOSE(WIN_CLOSE)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .step(ctr_step),
    .in_win(in_win), .win_last(win_last)
  );

  ocp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .oc_flag(oc_flag),
    .clear(clear), .in_win(in_win), .win_last(win_last),
    .ctr_clr(ctr_clr), .ctr_step(ctr_step), .state(state), .kill_q(kill_q)
  );

  assign cycle_kill   = kill_q;
  assign shutdown     = (state == OCP_TRIP);
  assign limit_active = (state == OCP_ARMED);
endmodule

// File: rtl/ocp_shutdown_timer_chk.sv
module ocp_shutdown_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_stb,
  input logic oc_flag,
  input logic clear,
  input logic cycle_kill,
  input logic shutdown,
  input logic limit_active
);
  // R1
  no_flag_without_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb && !clear && !shutdown) |=> !cycle_kill);
  // R2
  kill_from_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cycle_kill) |-> $past(sample_stb && oc_flag));
  // R4
  trip_excl_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown && limit_active));
  // R6
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !clear) |=> shutdown);
  // R6
  kill_in_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> cycle_kill);
  // R7
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!shutdown && !limit_active && !cycle_kill));
endmodule

bind ocp_shutdown_timer ocp_shutdown_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .oc_flag(oc_flag),
  .clear(clear), .cycle_kill(cycle_kill), .shutdown(shutdown),
  .limit_active(limit_active)
);

// File: tb/test_ocp_shutdown_timer.sv
module test_ocp_shutdown_timer;
  localparam int OPEN  = 3;
  localparam int CLOSE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0;
  logic oc_flag = 1'b0;
  logic clear = 1'b0;
  logic cycle_kill, shutdown, limit_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  bit m_arm, m_shut, m_kill;
  int m_n;
  string m_tag;

  always #2 clk = ~clk;

  ocp_shutdown_timer #(.WIN_OPEN(OPEN), .WIN_CLOSE(CLOSE)) i_ocp_shutdown_timer (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .oc_flag(oc_flag),
    .clear(clear), .cycle_kill(cycle_kill), .shutdown(shutdown),
    .limit_active(limit_active)
  );

  // compare {kill, shutdown, limit}
  task automatic check3(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {cycle_kill, shutdown, limit_active};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {kill,shut,limit} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_step(input bit oc);
    if (m_shut) begin
      m_kill = 1'b1; m_tag = "R6";
    end else if (!m_arm) begin
      m_kill = oc; m_tag = oc ? "R2" : "R1";
      if (oc) begin m_arm = 1'b1; m_n = 0; end
    end else begin
      m_n++;
      m_kill = oc; m_tag = "R3";
      if (oc && m_n >= OPEN) begin
        m_shut = 1'b1; m_arm = 1'b0; m_tag = "R4";
      end else if (m_n == CLOSE) begin
        m_arm = 1'b0; m_tag = "R5";
      end
    end
  endfunction

  task automatic strobe(input bit oc, input int gap);
    @(negedge clk);
    sample_stb = 1'b1; oc_flag = oc;
    model_step(oc);
    @(negedge clk);
    sample_stb = 1'b0; oc_flag = 1'b1;   // flag noise between strobes
    check3(m_tag, {m_kill, m_shut, m_arm});
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check3(m_shut ? "R6" : "R1", {m_shut, m_shut, m_arm});
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1; sample_stb = 1'b1; oc_flag = 1'b1;
    @(negedge clk);
    clear = 1'b0; sample_stb = 1'b0; oc_flag = 1'b0;
    m_arm = 1'b0; m_shut = 1'b0; m_kill = 1'b0; m_n = 0;
    check3("R7", 3'b000);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check3("R8", 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check3("R8", 3'b000);
    oc_flag = 1'b1;                       // R1: flag with no strobe
    repeat (3) begin @(negedge clk); check3("R1", 3'b000); end
    for (int gap = 0; gap < 3; gap++) begin
      for (int k = 1; k <= CLOSE + 2; k++) begin
        do_clear();
        strobe(1'b1, gap);                // first event
        for (int n = 1; n <= CLOSE + 2; n++) strobe(n == k, gap);
      end
    end
    // shutdown ignores strobes, then clear while tripped
    do_clear();
    strobe(1'b1, 1);
    for (int n = 1; n <= OPEN; n++) strobe(n == OPEN, 0);
    strobe(1'b0, 2);
    strobe(1'b1, 2);
    do_clear();
    // clear while in limit mode
    strobe(1'b1, 0);
    do_clear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule